// File: doc/BRIEF.md
# OLED Row and Frame Timing Generator

This block produces the row and frame cadence for a passive-matrix grayscale display driver. A single system clock runs the logic, and the master clock arrives as a one-cycle tick. A select input chooses whether that tick comes from the internal oscillator path or from an external clock path. The chosen tick is divided by a programmable ratio to form the display-clock enable. A row counter then counts a programmable number of display clocks per row and steps through the active rows. It emits a row-start strobe at each row and a frame-start strobe at row 0.

Three settings shape the timing: the divide ratio D, the row period K and the number of active rows. Each is written through a byte-wide command port as an opcode byte followed by one parameter byte. The frame rate is the master tick rate divided by D × K × rows. K is forced up to the sum of the three drive phases and the longest grayscale pulse. A written value below that sum raises an error flag. All written values wait in shadow registers and take effect together at the next frame boundary.

Top module: `oled_tgen_top`

## Requirements
- R1: When `clk_sel` is 1, only `int_osc_tick` advances the timing. When `clk_sel` is 0, only `ext_clk_tick` advances it, and the other tick has no effect.
- R2: `dclk_en` pulses once for every D selected master ticks. D = field + 1, where the field is bits [3:0] of the parameter byte of opcode B3h. A field of 0 gives divide-by-1 and a field of Fh gives divide-by-16.
- R3: Bits [7:4] of the B3h parameter appear on `osc_trim`, where a larger value requests a faster oscillator. The new value appears at the next frame boundary.
- R4: The parameter byte of opcode B2h sets the row period K. Successive `row_start` pulses are K display clocks apart.
- R5: The minimum row period is MIN = PH1_W + PH2_W + PH3_W + GS15_W, which is 18 by default. If the written K is below MIN, the row period used is MIN, and `cfg_err` is 1 from the cycle after the parameter write until a K of at least MIN is written.
- R6: The parameter byte of opcode A8h sets the number of active rows per frame to value + 1. `row_idx` runs from 0 to that value.
- R7: `row_start` is only high together with `dclk_en`. `frame_start` is high exactly when `row_start` is high for row 0.
- R8: A value written during a frame leaves that frame unchanged. It takes effect from the next `frame_start`.
- R9: The command port takes an opcode byte followed by exactly one parameter byte for B2h, B3h and A8h. Any other opcode byte is dropped, and the next byte is decoded as an opcode.
- R10: After reset the settings are D = 1, K = 32, 128 rows (A8h value 7Fh) and `osc_trim` = 8h. `row_idx` is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 1 | Master tick source: 1 selects the internal path, 0 selects the external path |
| int_osc_tick | input | 1 | Tick from the internal oscillator path |
| ext_clk_tick | input | 1 | Tick from the external clock path |
| cmd_wr | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command opcode or parameter byte |
| osc_trim | output | 4 | Oscillator frequency setting currently in effect |
| dclk_en | output | 1 | Display-clock enable pulse |
| row_start | output | 1 | First display clock of a row |
| frame_start | output | 1 | First display clock of a frame |
| row_idx | output | 8 | Current row number |
| cfg_err | output | 1 | Written row period is below the minimum |

## Verification
The main timing path is driven from a table of settings that mixes divide ratios 1, 2, 3 and 16, row counts of 1 to 4, and K values above, equal to and below the minimum. Measuring both the row spacing and the frame spacing for each entry separates a wrong divider from a wrong row period or row count. It also shows whether clamping happens at exactly MIN or one count off. Directed runs then feed an external tick every third cycle with the internal tick held high, and stop the external tick altogether, to expose a wrong source choice. Further runs write settings in the middle of a frame to show that the change is deferred to the frame boundary, and put a stray opcode ahead of a valid command to show that it does not take the following byte as its parameter.

// File: rtl/tgen_pkg.sv
// Package: shared command opcodes and the configuration record for the
// display timing generator. Assumes byte-wide command parameters.
package tgen_pkg;

    localparam logic [7:0] OP_ROW_PERIOD = 8'hB2;
    localparam logic [7:0] OP_CLOCK      = 8'hB3;
    localparam logic [7:0] OP_MUX        = 8'hA8;

    // One complete set of timing settings.
    typedef struct packed {
        logic [3:0] osc;   // oscillator frequency request
        logic [3:0] div;   // divide ratio minus one
        logic [7:0] k;     // row period in display clocks
        logic [7:0] mux;   // active rows minus one
    } tgen_cfg_t;

    // True for opcodes that carry one parameter byte.
    function automatic logic is_known_op(input logic [7:0] op);
        return (op == OP_ROW_PERIOD) || (op == OP_CLOCK) || (op == OP_MUX);
    endfunction

endpackage

// File: rtl/tgen_cmd_port.sv
// Command decoder: takes an opcode byte and then one parameter byte, and
// writes the parameter into the shadow configuration. Unknown opcodes are
// dropped without leaving the idle state. Assumes one byte per cmd_wr pulse.
module tgen_cmd_port
    import tgen_pkg::*;
#(
    parameter tgen_cfg_t CFG_RST = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output tgen_cfg_t  shadow
);

    logic       want_param;
    logic [7:0] op_q;

    // Track whether the next byte is a parameter, and which opcode it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_param <= 1'b0;
            op_q       <= '0;
        end else if (cmd_wr) begin
            if (want_param) begin
                want_param <= 1'b0;
            end else if (is_known_op(cmd_byte)) begin
                want_param <= 1'b1;
                op_q       <= cmd_byte;
            end
        end
    end

    // Store a parameter byte into the field its opcode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= CFG_RST;
        end else if (cmd_wr && want_param) begin
            unique case (op_q)
                OP_ROW_PERIOD: shadow.k   <= cmd_byte;
                OP_CLOCK: begin
                    shadow.osc <= cmd_byte[7:4];
                    shadow.div <= cmd_byte[3:0];
                end
                OP_MUX:        shadow.mux <= cmd_byte;
                default:       shadow     <= shadow;
            endcase
        end
    end

endmodule

// File: rtl/tgen_clk_div.sv
// Display-clock divider: emits a one-cycle enable after every (ratio + 1)
// source ticks. Assumes the source tick is already synchronous to clk.
module tgen_clk_div #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_tick,
    input  logic [RATIO_W-1:0] ratio_m1,
    output logic               dclk_en
);

    logic [RATIO_W-1:0] cnt;
    logic               hit;

    // A tick that lands on the last count ends the division period.
    always_comb hit = src_tick && (cnt >= ratio_m1);

    // Count source ticks and register the display-clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            dclk_en <= 1'b0;
        end else begin
            dclk_en <= hit;
            if (hit)           cnt <= '0;
            else if (src_tick) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tgen_row_ctr.sv
// Row and frame counter: counts display clocks within a row and rows within
// a frame, and produces row/frame start strobes plus a frame-end pulse.
// Assumes k_eff >= 1; the settings may change only on frame_end.
module tgen_row_ctr #(
    parameter int KW = 8,
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dclk_en,
    input  logic [KW-1:0] k_eff,
    input  logic [MW-1:0] last_row,
    output logic          row_start,
    output logic          frame_start,
    output logic          frame_end,
    output logic [MW-1:0] row_idx
);

    logic [KW-1:0] col;
    logic          col_last;
    logic          row_last;

    // Decode the ends of the row and the frame.
    always_comb begin
        col_last    = (col == k_eff - 1'b1);
        row_last    = (row_idx == last_row);
        row_start   = dclk_en && (col == '0);
        frame_start = row_start && (row_idx == '0);
        frame_end   = dclk_en && col_last && row_last;
    end

    // Advance the column and row positions on each display clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col     <= '0;
            row_idx <= '0;
        end else if (dclk_en) begin
            if (col_last) begin
                col     <= '0;
                row_idx <= row_last ? '0 : row_idx + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/oled_tgen_top.sv
// Display timing generator top: selects the master tick, divides it into
// display clocks, and drives the row/frame counter. The active settings are
// copied from the shadow settings at frame boundaries. Assumes both tick
// inputs are synchronous, single-cycle pulses.
module oled_tgen_top
    import tgen_pkg::*;
#(
    parameter int         PH1_W   = 5,
    parameter int         PH2_W   = 3,
    parameter int         PH3_W   = 2,
    parameter int         GS15_W  = 8,
    parameter logic [7:0] K_RST   = 8'd32,
    parameter logic [3:0] OSC_RST = 4'h8,
    parameter logic [7:0] MUX_RST = 8'h7F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_sel,
    input  logic       int_osc_tick,
    input  logic       ext_clk_tick,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output logic [3:0] osc_trim,
    output logic       dclk_en,
    output logic       row_start,
    output logic       frame_start,
    output logic [7:0] row_idx,
    output logic       cfg_err
);

    localparam logic [7:0] K_MIN   = 8'(PH1_W + PH2_W + PH3_W + GS15_W);
    localparam tgen_cfg_t  CFG_RST = '{osc: OSC_RST, div: 4'h0, k: K_RST, mux: MUX_RST};

    tgen_cfg_t  shadow;
    tgen_cfg_t  act_cfg;
    logic       src_tick;
    logic       frame_end;
    logic [7:0] k_eff;

    // Pick the master tick source.
    always_comb src_tick = clk_sel ? int_osc_tick : ext_clk_tick;

    // Raise the row period to the drive minimum; flag short written values.
    always_comb begin
        k_eff   = (act_cfg.k < K_MIN) ? K_MIN : act_cfg.k;
        cfg_err = (shadow.k < K_MIN);
    end

    // Copy the shadow settings at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         act_cfg <= CFG_RST;
        else if (frame_end) act_cfg <= shadow;
    end

    always_comb osc_trim = act_cfg.osc;

    tgen_cmd_port #(.CFG_RST(CFG_RST)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_byte (cmd_byte),
        .shadow   (shadow)
    );

    tgen_clk_div #(.RATIO_W(4)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .ratio_m1 (act_cfg.div),
        .dclk_en  (dclk_en)
    );

    tgen_row_ctr #(.KW(8), .MW(8)) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .dclk_en     (dclk_en),
        .k_eff       (k_eff),
        .last_row    (act_cfg.mux),
        .row_start   (row_start),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .row_idx     (row_idx)
    );

endmodule

// File: rtl/oled_tgen_chk.sv
// Checker for the timing generator: relates the strobes, the tick inputs
// and the active settings over time. Attached by the bind below.
module oled_tgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_sel,
    input logic       int_osc_tick,
    input logic       ext_clk_tick,
    input logic       dclk_en,
    input logic       row_start,
    input logic       frame_start,
    input logic [7:0] row_idx,
    input logic [7:0] mux_act,
    input logic [7:0] k_act,
    input logic [3:0] div_act,
    input logic       load_act
);

    AST_DCLK_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_en |-> $past(clk_sel ? int_osc_tick : ext_clk_tick)); // R1

    AST_ROW_ON_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |-> dclk_en); // R7

    AST_FRAME_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (row_start && row_idx == 8'd0)); // R7

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= mux_act); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_act |=> ($stable(k_act) && $stable(div_act) && $stable(mux_act))); // R8

endmodule

bind oled_tgen_top oled_tgen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .int_osc_tick (int_osc_tick),
    .ext_clk_tick (ext_clk_tick),
    .dclk_en      (dclk_en),
    .row_start    (row_start),
    .frame_start  (frame_start),
    .row_idx      (row_idx),
    .mux_act      (act_cfg.mux),
    .k_act        (act_cfg.k),
    .div_act      (act_cfg.div),
    .load_act     (frame_end)
);

// File: tb/oled_tgen_top_tb.sv
// Bench: table-driven timing checks, then directed tests for clock source,
// deferred updates, stray opcodes and reset.
module oled_tgen_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b1;
    logic       int_osc_tick = 1'b1;
    logic       ext_en = 1'b0;
    logic [1:0] ext_cnt = 2'd0;
    logic       ext_clk_tick;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [3:0] osc_trim;
    logic       dclk_en, row_start, frame_start, cfg_err;
    logic [7:0] row_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    // External tick every third cycle when enabled.
    always @(posedge clk) ext_cnt <= (ext_cnt == 2'd2) ? 2'd0 : ext_cnt + 2'd1;
    assign ext_clk_tick = ext_en && (ext_cnt == 2'd0);

    oled_tgen_top u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .int_osc_tick(int_osc_tick), .ext_clk_tick(ext_clk_tick),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .osc_trim(osc_trim),
        .dclk_en(dclk_en), .row_start(row_start), .frame_start(frame_start),
        .row_idx(row_idx), .cfg_err(cfg_err)
    );

    // Vectors: div field, osc field, K, mux, expected row cycles, frame cycles, cfg_err
    localparam int NV = 4;
    localparam int V_DIV [NV] = '{0, 2, 15, 1};
    localparam int V_OSC [NV] = '{3, 9, 15, 0};
    localparam int V_K   [NV] = '{20, 18, 5, 25};
    localparam int V_MUX [NV] = '{3, 1, 2, 0};
    localparam int V_ROW [NV] = '{20, 54, 288, 50};
    localparam int V_FRM [NV] = '{80, 108, 864, 50};
    localparam int V_ERR [NV] = '{0, 0, 1, 0};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_byte = b;
        @(posedge clk); #1;
        cmd_wr = 1'b0;
    endtask

    task automatic wait_frame();
        int n = 0;
        do begin @(posedge clk); #1; n++; end while (!frame_start && n < 20000);
    endtask

    task automatic wait_row();
        int n = 0;
        do begin @(posedge clk); #1; n++; end while (!row_start && n < 20000);
    endtask

    task automatic meas_row(output int n);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!row_start && n < 20000);
    endtask

    task automatic meas_frame(output int n);
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!frame_start && n < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rp, fp, cnt;
        repeat (3) @(posedge clk); #1;
        check("R10 row_start in reset", int'(row_start), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 row_idx", int'(row_idx), 0);
        check("R10 osc_trim", int'(osc_trim), 8);
        check("R10 cfg_err", int'(cfg_err), 0);
        wait_frame();
        meas_frame(fp);
        check("R10 R6 reset frame 128 rows x 32", fp, 4096);
        meas_row(rp);
        check("R10 R4 reset row period", rp, 32);

        // Table walk: main timing function
        for (int i = 0; i < NV; i++) begin
            send(8'hB3); send(8'((V_OSC[i] << 4) | V_DIV[i]));
            send(8'hB2); send(8'(V_K[i]));
            send(8'hA8); send(8'(V_MUX[i]));
            check("R5 cfg_err after K write", int'(cfg_err), V_ERR[i]);
            wait_frame();
            check("R3 osc_trim applied", int'(osc_trim), V_OSC[i]);
            meas_frame(fp);
            check("R2 R4 R5 R6 frame period", fp, V_FRM[i]);
            meas_row(rp);
            check("R2 R4 R5 row period", rp, V_ROW[i]);
        end

        // Deferred update: K and osc written mid-frame (R8, R3)
        send(8'hB3); send(8'h00);
        send(8'hB2); send(8'd20);
        send(8'hA8); send(8'd3);
        wait_frame();
        wait_frame();
        send(8'hB2); send(8'd40);
        send(8'hB3); send(8'h50);
        check("R8 R3 osc_trim held mid-frame", int'(osc_trim), 0);
        wait_row();
        meas_row(rp);
        check("R8 old row period kept in current frame", rp, 20);
        wait_frame();
        check("R3 osc_trim at boundary", int'(osc_trim), 5);
        meas_row(rp);
        check("R8 R4 new row period next frame", rp, 40);

        // Stray opcode: next byte is an opcode, not a parameter (R9)
        send(8'h55); send(8'hA8); send(8'd1);
        wait_frame();
        meas_frame(fp);
        check("R9 stray opcode dropped, A8h applied", fp, 80);

        // External source with internal tick still high (R1)
        clk_sel = 1'b0; ext_en = 1'b1;
        wait_frame();
        meas_frame(fp);
        check("R1 external tick drives timing", fp, 240);
        ext_en = 1'b0;
        repeat (10) @(posedge clk); #1;
        cnt = 0;
        for (int c = 0; c < 500; c++) begin
            @(posedge clk); #1;
            if (dclk_en) cnt++;
        end
        check("R1 internal tick ignored when external selected", cnt, 0);
        clk_sel = 1'b1;

        // cfg_err cleared by a legal K (R5)
        send(8'hB2); send(8'd17);
        check("R5 cfg_err at MIN-1", int'(cfg_err), 1);
        send(8'hB2); send(8'd18);
        check("R5 cfg_err at MIN", int'(cfg_err), 0);

        // Reset mid-run restores defaults (R10)
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        check("R10 osc_trim after reset", int'(osc_trim), 8);
        check("R10 row_idx after reset", int'(row_idx), 0);
        wait_frame();
        meas_row(rp);
        check("R10 row period after reset", rp, 32);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule